// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow word

This block is the arithmetic and logic stage of a small 16-bit processor. Each accepted operation carries a 4-bit opcode and two 16-bit operand values, `a` and `b`. One clock later the block returns five things: the value to write back to `a`, a 16-bit side word for the overflow register, a write enable for each of those two values, a pass/fail flag for the compare-and-skip opcodes, and the base cycle cost of the instruction.

The overflow register does not hold a one-bit carry. Arithmetic opcodes fill a whole 16-bit word: the carry, the borrow mask, the high product half, the fractional quotient, or the bits a shift pushed out. Division and modulo by zero do not trap. They return zero.

The surrounding processor decodes the operands, accesses memory, and skips the next instruction when `cond_out` is low. This block only computes the values. Every operation is combinational, and a single output register stage follows it. One operation can be accepted on every cycle.

Top module: `ovf_alu`

## Requirements
- R1: While reset is asserted, all outputs are zero: `out_valid`, `res_out`, `res_we`, `o_out`, `o_we`, `cond_out` and `cost_out`.
- R2: An operation presented with `in_valid` high appears on the outputs on the next clock, with `out_valid` high. A cycle with `in_valid` low drops `out_valid` and leaves every other output unchanged.
- R3: Opcode 1 copies `b`. Opcodes 9, 10 and 11 give a AND b, a OR b and a XOR b. All four raise `res_we`, keep `o_we` low with `o_out` = 0, and cost 1.
- R4: Opcode 2 gives the low 16 bits of a+b. `o_out` is 0x0001 on carry out and 0x0000 otherwise. `o_we` is high and the cost is 2.
- R5: Opcode 3 gives the low 16 bits of a-b. `o_out` is 0xFFFF when b > a (unsigned) and 0x0000 otherwise. `o_we` is high and the cost is 2.
- R6: Opcode 4 puts the low half of the 32-bit product a*b on `res_out` and the high half on `o_out`. `o_we` is high and the cost is 2.
- R7: Opcode 5 gives a/b, with `o_out` = ((a<<16)/b) & 0xFFFF. When b is 0, both are 0. `o_we` is high and the cost is 3.
- R8: Opcode 6 gives a%b, or 0 when b is 0. `o_we` stays low with `o_out` = 0, and the cost is 3.
- R9: Opcode 7 shifts `a` left by `b` through a 32-bit intermediate. The low half goes to `res_out` and the high half to `o_out`, so any shift of 16 or more gives a result of 0, and any shift of 32 or more also gives `o_out` = 0. The cost is 2.
- R10: Opcode 8 gives a>>b and `o_out` = ((a<<16)>>b) & 0xFFFF, which holds the bits shifted out below bit 0. The cost is 2.
- R11: Opcodes 12, 13, 14 and 15 test a==b, a!=b, a>b (unsigned) and (a&b)!=0 in that order. `cond_out` is high when the test passes. `res_we` and `o_we` stay low, and `res_out` and `o_out` are 0.
- R12: A compare costs 2 when it passes and 3 when it fails.
- R13: Opcode 0 (the non-basic escape) writes nothing. `res_out` and `o_out` are 0, `cond_out` is 1 and the cost is 0. Every non-compare opcode also reports `cond_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Basic opcode |
| a_in | input | 16 | First operand value |
| b_in | input | 16 | Second operand value |
| out_valid | output | 1 | Result registers hold a new operation |
| res_out | output | 16 | Value to write back to a |
| res_we | output | 1 | Write enable for `res_out` |
| o_out | output | 16 | Overflow side word |
| o_we | output | 1 | Write enable for `o_out` |
| cond_out | output | 1 | Compare passed (low means skip the next instruction) |
| cost_out | output | 2 | Base cycle cost |

## Verification
Two values always leave in the same cycle: the result word and its overflow word, and a failed compare together with its extra cost cycle. The vector table walks every opcode back-to-back, one per clock. The vectors include carry, borrow, a full-width product, division and modulo by zero, and shifts of exactly 16, of 20 and of 32. Each output cycle is judged as a whole: result, side word, both enables, flag and cost must all match the expected vector at once. Compares are run with both passing and failing operands, so the flag and the cost can be seen to change together.

// File: rtl/ovf_alu.sv
module ovf_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic [W-1:0] res_out,
  output logic         res_we,
  output logic [W-1:0] o_out,
  output logic         o_we,
  output logic         cond_out,
  output logic [1:0]   cost_out
);
  localparam int W2 = 2 * W;
  localparam logic [3:0] OP_ESC = 4'h0, OP_SET = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
                         OP_MUL = 4'h4, OP_DIV = 4'h5, OP_MOD = 4'h6, OP_SHL = 4'h7,
                         OP_SHR = 4'h8, OP_AND = 4'h9, OP_OR  = 4'hA, OP_XOR = 4'hB,
                         OP_IFE = 4'hC, OP_IFN = 4'hD, OP_IFG = 4'hE, OP_IFB = 4'hF;

  logic [W:0]    sum, dif;
  logic [W2-1:0] prod, shl_w, shr_w, div_w;
  logic [W-1:0]  quo, rem;
  logic          bz;

  assign bz    = (b_in == '0);
  assign sum   = {1'b0, a_in} + {1'b0, b_in};
  assign dif   = {1'b0, a_in} - {1'b0, b_in};
  assign prod  = {{W{1'b0}}, a_in} * {{W{1'b0}}, b_in};
  assign shl_w = {{W{1'b0}}, a_in} << b_in;
  assign shr_w = {a_in, {W{1'b0}}} >> b_in;
  assign quo   = bz ? '0 : a_in / b_in;
  assign rem   = bz ? '0 : a_in % b_in;
  assign div_w = bz ? '0 : {a_in, {W{1'b0}}} / {{W{1'b0}}, b_in};

  logic [W-1:0] n_res, n_o;
  logic         n_rwe, n_owe, n_cond, n_pass;
  logic [1:0]   n_cost;

  always_comb begin
    n_res  = '0;
    n_o    = '0;
    n_rwe  = 1'b1;
    n_owe  = 1'b0;
    n_cond = 1'b1;
    n_pass = 1'b1;
    n_cost = 2'd1;
    unique case (opcode)
      OP_ESC: begin n_rwe = 1'b0; n_cost = 2'd0; end
      OP_SET: n_res = b_in;
      OP_AND: n_res = a_in & b_in;
      OP_OR:  n_res = a_in | b_in;
      OP_XOR: n_res = a_in ^ b_in;
      OP_ADD: begin
        n_res = sum[W-1:0]; n_o = {{(W-1){1'b0}}, sum[W]}; n_owe = 1'b1; n_cost = 2'd2;
      end
      OP_SUB: begin
        n_res = dif[W-1:0]; n_o = {W{dif[W]}}; n_owe = 1'b1; n_cost = 2'd2;
      end
      OP_MUL: begin
        n_res = prod[W-1:0]; n_o = prod[W2-1:W]; n_owe = 1'b1; n_cost = 2'd2;
      end
      OP_DIV: begin
        n_res = quo; n_o = div_w[W-1:0]; n_owe = 1'b1; n_cost = 2'd3;
      end
      OP_MOD: begin n_res = rem; n_cost = 2'd3; end
      OP_SHL: begin
        n_res = shl_w[W-1:0]; n_o = shl_w[W2-1:W]; n_owe = 1'b1; n_cost = 2'd2;
      end
      OP_SHR: begin
        n_res = shr_w[W2-1:W]; n_o = shr_w[W-1:0]; n_owe = 1'b1; n_cost = 2'd2;
      end
      default: begin
        n_rwe = 1'b0;
        case (opcode)
          OP_IFE:  n_pass = (a_in == b_in);
          OP_IFN:  n_pass = (a_in != b_in);
          OP_IFG:  n_pass = (a_in > b_in);
          default: n_pass = ((a_in & b_in) != '0);
        endcase
        n_cond = n_pass;
        n_cost = n_pass ? 2'd2 : 2'd3;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_out   <= '0;
      res_we    <= 1'b0;
      o_out     <= '0;
      o_we      <= 1'b0;
      cond_out  <= 1'b0;
      cost_out  <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out  <= n_res;
        res_we   <= n_rwe;
        o_out    <= n_o;
        o_we     <= n_owe;
        cond_out <= n_cond;
        cost_out <= n_cost;
      end
    end
  end

  // R7
  always_comb begin
    if (!bz) div_split_chk: assert (div_w[W2-1:W] == quo);
  end

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_DIV && b_in == '0) |=> (res_out == '0 && o_out == '0 && o_we));

  // R8
  mod_keeps_o_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_MOD) |=> (!o_we && res_we && cost_out == 2'd3));

  // R3
  logic_no_o_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cost_out == 2'd1) |-> (!o_we && res_we));

  // R12
  cmp_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[3:2] == 2'b11) |=> (!res_we && !o_we && cost_out == (cond_out ? 2'd2 : 2'd3)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(o_out) && $stable(cost_out)));

  // R13
  esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ESC) |=> (!res_we && !o_we && cond_out && cost_out == 2'd0));
endmodule

// File: tb/ovf_alu_bench.sv
module ovf_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [15:0] a_in = 16'h0, b_in = 16'h0;
  logic        out_valid, res_we, o_we, cond_out;
  logic [15:0] res_out, o_out;
  logic [1:0]  cost_out;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ovf_alu u_ovf_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .res_out(res_out),
    .res_we(res_we), .o_out(o_out), .o_we(o_we), .cond_out(cond_out),
    .cost_out(cost_out)
  );

  // op, a, b, res, o, o_we, res_we, cond, cost
  localparam int NV = 30;
  localparam logic [72:0] VEC [NV] = '{
    {4'h1, 16'h1234, 16'hABCD, 16'hABCD, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd1},
    {4'h2, 16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h2, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h3, 16'h0001, 16'h0002, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h3, 16'h5000, 16'h1000, 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h4, 16'h1234, 16'h0100, 16'h3400, 16'h0012, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h4, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h5, 16'h0007, 16'h0002, 16'h0003, 16'h8000, 1'b1, 1'b1, 1'b1, 2'd3},
    {4'h5, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd3},
    {4'h5, 16'h0001, 16'h0003, 16'h0000, 16'h5555, 1'b1, 1'b1, 1'b1, 2'd3},
    {4'h6, 16'h0007, 16'h0003, 16'h0001, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd3},
    {4'h6, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd3},
    {4'h7, 16'h8001, 16'h0001, 16'h0002, 16'h0001, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h7, 16'h1234, 16'h0010, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h7, 16'h1234, 16'h0014, 16'h0000, 16'h2340, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h7, 16'h1234, 16'h0020, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h8, 16'h8001, 16'h0001, 16'h4000, 16'h8000, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h8, 16'h1234, 16'h0010, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b1, 2'd2},
    {4'h9, 16'hF0F0, 16'hFF00, 16'hF000, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd1},
    {4'hA, 16'hF0F0, 16'h0F00, 16'hFFF0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd1},
    {4'hB, 16'hFFFF, 16'h0F0F, 16'hF0F0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd1},
    {4'hC, 16'h0005, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'hC, 16'h0005, 16'h0006, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3},
    {4'hD, 16'h0005, 16'h0006, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'hD, 16'h0007, 16'h0007, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3},
    {4'hE, 16'h8000, 16'h7FFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'hE, 16'h0005, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3},
    {4'hF, 16'h00F0, 16'h0010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'hF, 16'h0F00, 16'h00F0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3},
    {4'h0, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0: return "R13";
      4'h1, 4'h9, 4'hA, 4'hB: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R8";
      4'h7: return "R9";
      4'h8: return "R10";
      default: return "R11/R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [40:0] got, input logic [40:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {1'b0, out_valid, res_out, o_out, o_we, res_we, cond_out, cost_out}, 41'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {opcode, a_in, b_in} = VEC[i][72:37];
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(tag_of(VEC[i][72:69]),
            {out_valid, res_out, o_out, o_we, res_we, cond_out, cost_out},
            {1'b1, VEC[i][36:0]});
    end
    // R2 hold with in_valid low, operands changed
    opcode = 4'h2; a_in = 16'hFFFF; b_in = 16'hFFFF; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", {out_valid, res_out, o_out, o_we, res_we, cond_out, cost_out},
          {1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0});
    // R2 next accepted op lands one cycle later
    in_valid = 1'b1; opcode = 4'h4; a_in = 16'h0100; b_in = 16'h0100;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2/R6", {out_valid, res_out, o_out, o_we, res_we, cond_out, cost_out},
          {1'b1, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 2'd2});
    // R12 fail then pass compare back-to-back
    in_valid = 1'b1; opcode = 4'hE; a_in = 16'h0001; b_in = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    check("R12", {out_valid, 24'd0, cond_out, cost_out, 13'd0},
          {1'b1, 24'd0, 1'b0, 2'd3, 13'd0});
    a_in = 16'hFFFF; b_in = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12", {out_valid, 24'd0, cond_out, cost_out, 13'd0},
          {1'b1, 24'd0, 1'b1, 2'd2, 13'd0});
    // R1 reset again clears a live result
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", {1'b0, out_valid, res_out, o_out, o_we, res_we, cond_out, cost_out}, 41'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule